// File: doc/BRIEF.md
# Truth-Table Bitwise Logic Unit

This execution unit evaluates an arbitrary two-input Boolean function across every bit of two data words. The function is not encoded as an opcode. Each micro-op carries a 4-bit truth table, and every bit position looks up its own output in that table. One datapath therefore covers all sixteen two-input functions, including AND, OR, XOR, NAND, NOR, equivalence, and the complemented-operand forms.

Operand a always comes from the first register source. Operand b comes from the second register source, or from a pre-formatted immediate when the micro-op is in immediate form. The decoder formats the immediate before it arrives: a 16-bit value is zero-extended, or it is placed 16 bits up for the shifted variants. The unit uses the immediate exactly as received.

The result leaves one clock later from a register, at full width, together with the echoed destination tag. When the micro-op asks for it, the unit also produces a signed-compare condition nibble that describes the result.

Top module: `bitfn_unit`

## Requirements
- R1: For each bit position i, the result bit equals `lut[idx]`, where `idx = {b[i], a[i]}`. Operand a selects truth-table index bit 0 and operand b selects index bit 1. All positions use the same table.
- R2: In register form (`is_imm` = 0), operand a is `src_a` and operand b is `src_b`. The `imm` input has no effect on the result.
- R3: In immediate form (`is_imm` = 1), operand a is `src_a` and operand b is `imm`, used bit for bit with no extension or shift. The `src_b` input has no effect on the result.
- R4: The following codes give the named functions:
  - AND = 4'b1000
  - OR = 4'b1110
  - XOR = 4'b0110
  - NAND = 4'b0111
  - NOR = 4'b0001
  - EQV = 4'b1001
  - a AND NOT b = 4'b0010
  - a OR NOT b = 4'b1011
- R5: `out_valid` equals `in_valid` from the previous clock. When `out_valid` is 1, `result` and `tag_out` hold the values computed from that accepted micro-op.
- R6: `cr_valid` is 1 exactly one clock after an accepted micro-op that had `want_cr` = 1. Whenever `cr_valid` is 0, `cr` reads 4'b0000.
- R7: When `cr_valid` is 1, the nibble `cr` = {LT, GT, EQ, SO} describes the result:
  - `cr[3]` (LT) is result bit 63.
  - `cr[1]` (EQ) is 1 when the result is zero.
  - `cr[2]` (GT) is 1 when the result is neither negative nor zero.
  - `cr[0]` (SO) is 0.
- R8: A synchronous active-high `rst` clears `out_valid`, `cr_valid` and `cr` at the next clock edge. This holds even if `in_valid` is 1 during that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Micro-op present this cycle |
| is_imm | input | 1 | Operand b taken from `imm` instead of `src_b` |
| lut | input | 4 | Per-bit truth table |
| src_a | input | 64 | First register operand (operand a) |
| src_b | input | 64 | Second register operand |
| imm | input | 64 | Pre-formatted immediate operand |
| want_cr | input | 1 | Request condition nibble |
| tag_in | input | 6 | Destination tag |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Registered result |
| cr_valid | output | 1 | Condition nibble valid |
| cr | output | 4 | Condition nibble {LT, GT, EQ, SO} |
| tag_out | output | 6 | Echoed destination tag |

## Verification
Two things are produced from the same result in the same cycle: the data result, and the condition nibble that describes it. A wrong nibble therefore cannot hide behind a correct result. The bench raises `want_cr` on alternating micro-ops across all sixteen tables and both operand forms. It includes operand pairs chosen to give zero, all-ones and sign-bit-only results. Every clock it judges the result, the tag, `cr_valid` and the full nibble against a bit-by-bit reference. A reset asserted while `in_valid` is 1 checks that reset wins over an accepted micro-op in that cycle.

// File: rtl/bitfn_pkg.sv
package bitfn_pkg;
   localparam int TT_W = 4;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_nib_t;

   localparam logic [TT_W-1:0] TT_AND  = 4'b1000;
   localparam logic [TT_W-1:0] TT_OR   = 4'b1110;
   localparam logic [TT_W-1:0] TT_XOR  = 4'b0110;
   localparam logic [TT_W-1:0] TT_NAND = 4'b0111;
   localparam logic [TT_W-1:0] TT_NOR  = 4'b0001;
   localparam logic [TT_W-1:0] TT_EQV  = 4'b1001;
   localparam logic [TT_W-1:0] TT_ANDN = 4'b0010;
   localparam logic [TT_W-1:0] TT_ORN  = 4'b1011;
endpackage

// File: rtl/bitfn_opsel.sv
module bitfn_opsel #(
   parameter int DATA_W = 64
) (
   input  logic              use_imm,
   input  logic [DATA_W-1:0] reg_b,
   input  logic [DATA_W-1:0] imm_b,
   output logic [DATA_W-1:0] op_b
);
   // R2 / R3: choose the second operand
   assign op_b = use_imm ? imm_b : reg_b;
endmodule

// File: rtl/bitfn_array.sv
module bitfn_array
   import bitfn_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [TT_W-1:0]   table_i,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] y
);
   // R1: one truth-table lookup per bit
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic [1:0] sel;
      assign sel  = {op_b[i], op_a[i]};
      assign y[i] = table_i[sel];
   end
endmodule

// File: rtl/bitfn_cond.sv
module bitfn_cond
   import bitfn_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] value,
   output cond_nib_t         nib
);
   logic is_zero;
   assign is_zero = (value == '0);

   // R7: signed classification of the result
   always_comb begin
      nib.lt = value[DATA_W-1];
      nib.eq = is_zero;
      nib.gt = ~value[DATA_W-1] & ~is_zero;
      nib.so = 1'b0;
   end
endmodule

// File: rtl/bitfn_unit.sv
module bitfn_unit
   import bitfn_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 6,
   parameter bit HAS_CR = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              is_imm,
   input  logic [3:0]        lut,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] imm,
   input  logic              want_cr,
   input  logic [TAG_W-1:0]  tag_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              cr_valid,
   output logic [3:0]        cr,
   output logic [TAG_W-1:0]  tag_out
);
   localparam int NIB_W = $bits(cond_nib_t);

   if (DATA_W < 2) begin : g_chk_w
      $error("bitfn_unit: DATA_W must be at least 2");
   end
   if (TAG_W < 1) begin : g_chk_t
      $error("bitfn_unit: TAG_W must be at least 1");
   end
   if (NIB_W != 4) begin : g_chk_n
      $error("bitfn_unit: condition nibble must be 4 bits");
   end

   logic [DATA_W-1:0] op_b;
   logic [DATA_W-1:0] y;
   cond_nib_t         nib;
   logic              cr_take;

   bitfn_opsel #(.DATA_W(DATA_W)) u_opsel (
      .use_imm (is_imm),
      .reg_b   (src_b),
      .imm_b   (imm),
      .op_b    (op_b)
   );

   bitfn_array #(.DATA_W(DATA_W)) u_array (
      .table_i (lut),
      .op_a    (src_a),
      .op_b    (op_b),
      .y       (y)
   );

   if (HAS_CR) begin : g_cr
      bitfn_cond #(.DATA_W(DATA_W)) u_cond (
         .value (y),
         .nib   (nib)
      );
      assign cr_take = in_valid & want_cr;
   end else begin : g_no_cr
      assign nib     = '0;
      assign cr_take = 1'b0;
   end

   // R5 / R6 / R8: single output register stage
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         cr_valid  <= 1'b0;
         cr        <= '0;
         result    <= '0;
         tag_out   <= '0;
      end else begin
         out_valid <= in_valid;
         cr_valid  <= cr_take;
         cr        <= cr_take ? nib : '0;
         if (in_valid) begin
            result  <= y;
            tag_out <= tag_in;
         end
      end
   end
endmodule

// File: rtl/bitfn_unit_chk.sv
module bitfn_unit_chk #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              is_imm,
   input logic [3:0]        lut,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic              want_cr,
   input logic [TAG_W-1:0]  tag_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              cr_valid,
   input logic [3:0]        cr,
   input logic [TAG_W-1:0]  tag_out
);
   assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_idle_follows_R5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_tag_echo_R5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> tag_out == $past(tag_in));
   assert_and_result_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !is_imm && lut == 4'b1000) |=> result == $past(src_a & src_b));
   assert_cr_request_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && want_cr) |=> cr_valid);
   assert_cr_within_valid_R6: assert property (@(posedge clk) disable iff (rst)
      cr_valid |-> out_valid);
   assert_cr_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !cr_valid |-> cr == 4'b0000);
   assert_cr_one_class_R7: assert property (@(posedge clk) disable iff (rst)
      cr_valid |-> ($countones(cr[3:1]) == 1 && !cr[0]));
   assert_cr_eq_zero_R7: assert property (@(posedge clk) disable iff (rst)
      cr_valid |-> (cr[1] == (result == '0)));
   assert_cr_sign_R7: assert property (@(posedge clk) disable iff (rst)
      cr_valid |-> (cr[3] == result[DATA_W-1]));
   assert_reset_clears_R8: assert property (@(posedge clk)
      rst |=> (!out_valid && !cr_valid));
endmodule

bind bitfn_unit bitfn_unit_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .is_imm    (is_imm),
   .lut       (lut),
   .src_a     (src_a),
   .src_b     (src_b),
   .want_cr   (want_cr),
   .tag_in    (tag_in),
   .out_valid (out_valid),
   .result    (result),
   .cr_valid  (cr_valid),
   .cr        (cr),
   .tag_out   (tag_out)
);

// File: tb/test_bitfn_unit.sv
`timescale 1ns/1ps
module test_bitfn_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid, is_imm, want_cr;
   logic [3:0]  lut;
   logic [63:0] src_a, src_b, imm;
   logic [5:0]  tag_in;
   logic        out_valid, cr_valid;
   logic [63:0] result;
   logic [3:0]  cr;
   logic [5:0]  tag_out;

   int total = 0;
   int bad   = 0;

   // expected state
   logic        e_v = 1'b0, e_cv = 1'b0;
   logic [63:0] e_res = '0;
   logic [3:0]  e_cr = '0;
   logic [5:0]  e_tag = '0;

   always #2 clk = ~clk;

   bitfn_unit i_bitfn_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .is_imm(is_imm), .lut(lut),
      .src_a(src_a), .src_b(src_b), .imm(imm), .want_cr(want_cr), .tag_in(tag_in),
      .out_valid(out_valid), .result(result), .cr_valid(cr_valid), .cr(cr),
      .tag_out(tag_out)
   );

   function automatic logic [63:0] model(input logic [3:0] t, input logic [63:0] a,
                                         input logic [63:0] b);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) begin
         int k;
         k = (a[i] ? 1 : 0) + (b[i] ? 2 : 0);
         r[i] = t[k];
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare(input string req);
      chk(out_valid === e_v, "R5 out_valid", {63'b0, out_valid}, {63'b0, e_v});
      chk(cr_valid === e_cv, "R6 cr_valid", {63'b0, cr_valid}, {63'b0, e_cv});
      chk(cr === e_cr, {req, " R7 cr"}, {60'b0, cr}, {60'b0, e_cr});
      if (e_v) begin
         chk(result === e_res, {req, " result"}, result, e_res);
         chk(tag_out === e_tag, "R5 tag", {58'b0, tag_out}, {58'b0, e_tag});
      end
   endtask

   task automatic step(input bit r, input bit v, input bit im, input logic [3:0] t,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] iv,
                       input bit w, input logic [5:0] tg, input string req);
      logic [63:0] x;
      @(negedge clk);
      rst = r; in_valid = v; is_imm = im; lut = t; src_a = a; src_b = b;
      imm = iv; want_cr = w; tag_in = tg;
      @(posedge clk);
      if (r) begin
         e_v = 1'b0; e_cv = 1'b0; e_cr = '0;
      end else begin
         e_v = v;
         x = model(t, a, im ? iv : b);
         if (v) begin
            e_res = x; e_tag = tg;
         end
         e_cv = v & w;
         e_cr = e_cv ? {x[63], (!x[63] && x != 0), (x == 0), 1'b0} : 4'b0000;
      end
      #1 compare(req);
   endtask

   // R4: named codes checked against the language's own operators
   task automatic named(input logic [3:0] t, input logic [63:0] want, input string nm);
      step(0, 1, 0, t, 64'hF0F0_FF00_1234_5678, 64'hFF00_F0F0_8765_4321, '0, 1, 6'h2A,
           {"R4 ", nm});
      chk(result === want, {"R4 direct ", nm}, result, want);
   endtask

   localparam logic [63:0] PA = 64'hAAAA_AAAA_AAAA_AAAA;
   localparam logic [63:0] PC = 64'hCCCC_CCCC_CCCC_CCCC;
   localparam logic [63:0] ON = '1;
   localparam logic [63:0] NA = 64'hF0F0_FF00_1234_5678;
   localparam logic [63:0] NB = 64'hFF00_F0F0_8765_4321;

   initial begin
      #(4 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1; in_valid = 0; is_imm = 0; lut = 0; src_a = 0; src_b = 0;
      imm = 0; want_cr = 0; tag_in = 0;
      // R8: reset state
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 reset");
      step(1, 1, 0, 4'hF, ON, ON, 0, 1, 6'h11, "R8 reset with valid");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 idle");

      // R1 / R2: all tables, register form, imm carries garbage
      for (int t = 0; t < 16; t++) begin
         step(0, 1, 0, t[3:0], PA, PC, ON, t[0], t[5:0], "R1 R2 pattern");
         step(0, 1, 0, t[3:0], '0, '0, PA, 1, 6'h30, "R1 R2 zeros");
         step(0, 1, 0, t[3:0], ON, ON, '0, 1, 6'h31, "R1 R2 ones");
         step(0, 1, 0, t[3:0], '0, ON, PC, !t[0], 6'h32, "R1 R2 mixed");
      end

      // R3: immediate form, src_b carries garbage
      for (int t = 0; t < 16; t++) begin
         step(0, 1, 1, t[3:0], PA, ON, 64'h0000_0000_0000_89AB, t[1], 6'h20, "R3 imm low");
         step(0, 1, 1, t[3:0], PC, PA, 64'h0000_0000_89AB_0000, 1, 6'h21, "R3 imm shifted");
         step(0, 1, 1, t[3:0], ON, '0, '0, 1, 6'h22, "R3 imm zero");
         step(0, 1, 1, t[3:0], '0, ON, ON, 1, 6'h23, "R3 imm ones");
      end

      named(4'b1000, NA & NB, "and");
      named(4'b1110, NA | NB, "or");
      named(4'b0110, NA ^ NB, "xor");
      named(4'b0111, ~(NA & NB), "nand");
      named(4'b0001, ~(NA | NB), "nor");
      named(4'b1001, ~(NA ^ NB), "eqv");
      named(4'b0010, NA & ~NB, "andc");
      named(4'b1011, NA | ~NB, "orc");

      // R7: zero, negative, positive results
      step(0, 1, 0, 4'b1000, ON, '0, '0, 1, 6'h01, "R7 eq zero");
      chk(cr === 4'b0010, "R7 eq nibble", {60'b0, cr}, 64'h2);
      step(0, 1, 0, 4'b1110, 64'h8000_0000_0000_0000, '0, '0, 1, 6'h02, "R7 lt");
      chk(cr === 4'b1000, "R7 lt nibble", {60'b0, cr}, 64'h8);
      step(0, 1, 0, 4'b1110, 64'h0000_0000_0000_0001, '0, '0, 1, 6'h03, "R7 gt");
      chk(cr === 4'b0100, "R7 gt nibble", {60'b0, cr}, 64'h4);

      // R6: no request gives a quiet nibble
      step(0, 1, 0, 4'b1110, ON, ON, '0, 0, 6'h04, "R6 no request");
      step(0, 0, 0, 4'b1110, ON, ON, '0, 1, 6'h05, "R6 request while idle");

      // R5: result holds through idle cycles
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 idle after");
      chk(result === ON, "R5 hold", result, ON);

      // R8: reset mid-stream
      step(0, 1, 0, 4'b0110, PA, PC, 0, 1, 6'h3F, "R8 before");
      step(1, 1, 0, 4'b0110, PA, PC, 0, 1, 6'h3E, "R8 mid-stream");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 after");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule